// File: doc/BRIEF.md
# Register Write Protection Unit

This unit sits between a bus master and the memory-mapped configuration registers of one peripheral. It passes accesses through to the peripheral side only when they are allowed. Each protected register has its own soft-lock bit. One global control word holds a hard-lock bit and a supervisor-only enable. The lock bits and the control word sit in a protection window of their own, which is separate from the peripheral's register space.

A soft lock stops writes to one register, and software can release it again. A hard lock stops writes to every protected register. It also freezes the protection settings, and only a reset clears it. When supervisor-only mode is on, every user-mode access to the unit is refused, in addition to any checks the peripheral makes itself. A refused access is not forwarded and is answered with a one-cycle error. Read data and the error come back one clock after the access.

Top module: `regprot_unit`

## Requirements
- R1: With the default 8-bit address, `bus_addr[7]=0` selects the peripheral window: `per_addr` is `bus_addr[6:0]`, and offsets 0 to NUM_REGS-1 are the protected registers. `bus_addr[7:6]=2'b11` selects the global control word: bit 0 is the hard lock and bit 1 is supervisor-only. `bus_addr[7:6]=2'b10` selects the soft-lock bit, held in data bit 0, of the register numbered `bus_addr[2:0]`.
- R2: A permitted peripheral access appears on `per_we`/`per_re` in the same cycle, with address and data passed through. Its read data shows on `bus_rdata` one cycle later.
- R3: While a register's soft-lock bit is 1, a write to that register is not forwarded and the register keeps its value. Other registers can still be written.
- R4: Writing 0 to a soft-lock bit releases it, and later writes to that register are forwarded.
- R5: While the hard lock is 1, writes to every protected register are refused. Peripheral offsets at or above NUM_REGS are not affected.
- R6: While the hard lock is 1, writes to the soft-lock bits and to the control word are refused and change nothing. No software write clears the hard lock.
- R7: With supervisor-only set, any user-mode (`bus_sup=0`) read or write to either window is refused and not forwarded. Supervisor accesses still work.
- R8: Reads of protected registers are forwarded whatever the lock state is.
- R9: A refused access drives `bus_err` high for exactly the following cycle, and `bus_rdata` is 0 in that cycle. A permitted access or an idle cycle gives `bus_err=0`.
- R10: The lock bits and the control word read back their stored values. Reset clears all of them to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | DATA_W | Bus write data |
| bus_we | input | 1 | Write request (takes priority over read) |
| bus_re | input | 1 | Read request |
| bus_sup | input | 1 | Requester is in supervisor mode |
| bus_rdata | output | DATA_W | Read data, one cycle after the access |
| bus_err | output | 1 | Transfer error, one cycle after a refused access |
| per_addr | output | ADDR_W-1 | Peripheral register offset |
| per_wdata | output | DATA_W | Peripheral write data |
| per_we | output | 1 | Forwarded write strobe |
| per_re | output | 1 | Forwarded read strobe |
| per_rdata | input | DATA_W | Peripheral read data |

## Verification
A lock bit stored in the wrong state shows up on the very next write to its register. Either a wanted write gets an error, or an unwanted write lands and can be seen on the next read. A hard lock that clears itself shows up on the next write to the protection window, and also when the control word is read back. A wrong privilege decision shows up as an error, or a missing error, in the cycle after the user-mode access. So every fault reaches the ports within two accesses of the stimulus that exposes it.

// File: rtl/regprot_pkg.sv
package regprot_pkg;
  typedef struct packed {
    logic sup_only;
    logic hard_lock;
  } gcr_t;

  typedef enum logic [1:0] {
    WIN_PERI = 2'd0,
    WIN_LOCK = 2'd1,
    WIN_GCR  = 2'd2
  } win_e;
endpackage

// File: rtl/regprot_filter.sv
module regprot_filter
  import regprot_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 8,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                we,
  input  logic                re,
  input  logic                sup,
  input  gcr_t                gcr,
  input  logic [NUM_REGS-1:0] soft_lock,
  output win_e                win,
  output logic [IDX_W-1:0]    idx,
  output logic                fwd_we,
  output logic                fwd_re,
  output logic                sl_we,
  output logic                gcr_we,
  output logic                loc_re,
  output logic                blocked
);
  localparam int EXT = 1 << IDX_W;

  logic [EXT-1:0] sl_ext;
  logic           is_prot;
  logic           priv_ok;
  logic           locked;
  logic           rd;

  always_comb begin
    sl_ext = '0;
    sl_ext[NUM_REGS-1:0] = soft_lock;
    if (!addr[ADDR_W-1])      win = WIN_PERI;
    else if (addr[ADDR_W-2])  win = WIN_GCR;
    else                      win = WIN_LOCK;
    idx     = addr[IDX_W-1:0];
    is_prot = (ADDR_W'({1'b0, addr[ADDR_W-2:0]}) < ADDR_W'(NUM_REGS));
    priv_ok = !gcr.sup_only || sup;
    locked  = is_prot && (gcr.hard_lock || sl_ext[idx]);
    rd      = re && !we;
    fwd_we  = (win == WIN_PERI) && we && priv_ok && !locked;
    fwd_re  = (win == WIN_PERI) && rd && priv_ok;
    sl_we   = (win == WIN_LOCK) && we && priv_ok && !gcr.hard_lock;
    gcr_we  = (win == WIN_GCR)  && we && priv_ok && !gcr.hard_lock;
    loc_re  = (win != WIN_PERI) && rd && priv_ok;
    blocked = (we || re) && !(fwd_we || fwd_re || sl_we || gcr_we || loc_re);
  end
endmodule

// File: rtl/regprot_lockbank.sv
module regprot_lockbank #(
  parameter int NUM_REGS = 8,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hard_lock,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic                wr_val,
  output logic [NUM_REGS-1:0] soft_lock
);
  logic [NUM_REGS-1:0] sl_q;
  logic [NUM_REGS-1:0] sl_en;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_bit
    always_comb sl_en[i] = wr_en && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sl_q[i] <= 1'b0;
      else if (sl_en[i]) sl_q[i] <= wr_val;
    end
  end

  assign soft_lock = sl_q;

  // R6: protection settings frozen under hard lock
  p_locks_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hard_lock |=> $stable(sl_q));
endmodule

// File: rtl/regprot_gcr.sv
module regprot_gcr
  import regprot_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_val,
  output gcr_t       gcr
);
  gcr_t gcr_q, gcr_d;

  always_comb begin
    gcr_d = gcr_q;
    if (wr_en) begin
      gcr_d.hard_lock = gcr_q.hard_lock | wr_val[0];
      gcr_d.sup_only  = wr_val[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gcr_q <= '0;
    else        gcr_q <= gcr_d;
  end

  assign gcr = gcr_q;

  // R6: hard lock is sticky until reset
  p_hard_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gcr_q.hard_lock |=> gcr_q.hard_lock);
endmodule

// File: rtl/regprot_unit.sv
module regprot_unit
  import regprot_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic              bus_sup,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  output logic [ADDR_W-2:0] per_addr,
  output logic [DATA_W-1:0] per_wdata,
  output logic              per_we,
  output logic              per_re,
  input  logic [DATA_W-1:0] per_rdata
);
  localparam int EXT = 1 << IDX_W;

  logic [1:0]          rst_sync;
  logic                rst_i_n;
  gcr_t                gcr;
  logic [NUM_REGS-1:0] soft_lock;
  logic [EXT-1:0]      sl_ext;
  win_e                win;
  logic [IDX_W-1:0]    idx;
  logic                fwd_we, fwd_re, sl_we, gcr_we, loc_re, blocked;
  logic [DATA_W-1:0]   rd_mux, rdata_d, rdata_q;
  logic                err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  regprot_filter #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_filter (
    .addr(bus_addr), .we(bus_we), .re(bus_re), .sup(bus_sup),
    .gcr(gcr), .soft_lock(soft_lock), .win(win), .idx(idx),
    .fwd_we(fwd_we), .fwd_re(fwd_re), .sl_we(sl_we), .gcr_we(gcr_we),
    .loc_re(loc_re), .blocked(blocked)
  );

  regprot_lockbank #(.NUM_REGS(NUM_REGS)) u_locks (
    .clk(clk), .rst_n(rst_i_n), .hard_lock(gcr.hard_lock), .wr_en(sl_we),
    .wr_idx(idx), .wr_val(bus_wdata[0]), .soft_lock(soft_lock)
  );

  regprot_gcr u_gcr (
    .clk(clk), .rst_n(rst_i_n), .wr_en(gcr_we),
    .wr_val(bus_wdata[1:0]), .gcr(gcr)
  );

  always_comb begin
    sl_ext = '0;
    sl_ext[NUM_REGS-1:0] = soft_lock;
    rd_mux = '0;
    case (win)
      WIN_PERI: rd_mux = per_rdata;
      WIN_LOCK: rd_mux[0] = sl_ext[idx];
      default:  rd_mux[1:0] = {gcr.sup_only, gcr.hard_lock};
    endcase
    rdata_d = (fwd_re || loc_re) ? rd_mux : '0;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      err_q   <= blocked;
    end
  end

  assign per_addr  = bus_addr[ADDR_W-2:0];
  assign per_wdata = bus_wdata;
  assign per_we    = fwd_we;
  assign per_re    = fwd_re;
  assign bus_rdata = rdata_q;
  assign bus_err   = err_q;

  // R3 / R5: no write reaches a locked protected register
  p_locked_no_write_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (per_we && (ADDR_W'({1'b0, per_addr}) < ADDR_W'(NUM_REGS)))
      |-> !(gcr.hard_lock || sl_ext[per_addr[IDX_W-1:0]]));

  // R7: user mode never reaches the peripheral in supervisor-only mode
  p_user_blocked_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (gcr.sup_only && !bus_sup) |-> !(per_we || per_re));

  // R9: an error follows only an access that was not forwarded
  p_err_no_fwd_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    bus_err |-> $past(!per_we && !per_re));

  // R9: error cycle returns zero data
  p_err_zero_data_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    bus_err |-> (bus_rdata == '0));
endmodule

// File: tb/regprot_unit_tb_top.sv
`timescale 1ns/1ps
module regprot_unit_tb_top;
  localparam int AW = 8;
  localparam int DW = 32;

  typedef struct {
    int          cyc;
    logic        exp_err;
    logic        chk_rd;
    logic [DW-1:0] exp_rd;
    string       tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata, per_wdata, per_rdata;
  logic bus_we, bus_re, bus_sup, bus_err, per_we, per_re;
  logic [AW-2:0] per_addr;
  logic [DW-1:0] pmem [16];

  int tests = 0, fails = 0, cyc = 0;
  item_t q[$];

  always #2 clk = ~clk;

  regprot_unit #(.ADDR_W(AW), .DATA_W(DW), .NUM_REGS(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_sup(bus_sup),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .per_addr(per_addr),
    .per_wdata(per_wdata), .per_we(per_we), .per_re(per_re),
    .per_rdata(per_rdata)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) pmem[i] <= '0;
    end else if (per_we) begin
      pmem[per_addr[3:0]] <= per_wdata;
    end
  end
  assign per_rdata = pmem[per_addr[3:0]];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input logic ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].cyc < cyc) begin
        item_t it;
        it = q.pop_front();
        check(bus_err == it.exp_err, {it.tag, " err"}, DW'(bus_err), DW'(it.exp_err));
        if (it.chk_rd)
          check(bus_rdata == it.exp_rd, {it.tag, " rdata"}, bus_rdata, it.exp_rd);
      end
    end
  end

  task automatic acc(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic w,
                     input logic r, input logic s, input logic e, input logic c,
                     input logic [DW-1:0] x, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = w; bus_re = r; bus_sup = s;
    it.cyc = cyc; it.exp_err = e; it.chk_rd = c; it.exp_rd = x; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic s,
                    input logic e, input string tag);
    acc(a, d, 1'b1, 1'b0, s, e, 1'b0, '0, tag);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic s, input logic e,
                    input logic [DW-1:0] x, input string tag);
    acc(a, '0, 1'b0, 1'b1, s, e, 1'b1, e ? '0 : x, tag);
  endtask

  task automatic idle();
    acc('0, '0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, "R9 idle");
  endtask

  task automatic do_reset();
    @(negedge clk);
    bus_we = 0; bus_re = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    bus_addr = '0; bus_wdata = '0; bus_we = 0; bus_re = 0; bus_sup = 1;
    rst_n = 1'b0;
    do_reset();
    check(bus_err == 1'b0, "R9 reset err", DW'(bus_err), '0);
    rd(8'hC0, 1, 0, 32'h0, "R10 control reset");
    rd(8'h82, 1, 0, 32'h0, "R10 lock reset");
    wr(8'h02, 32'hA5, 1, 0, "R2 write");
    rd(8'h02, 1, 0, 32'hA5, "R2 read");
    wr(8'h82, 32'h1, 1, 0, "R3 set lock");
    rd(8'h82, 1, 0, 32'h1, "R10 lock readback");
    wr(8'h02, 32'h5A, 1, 1, "R3 locked write");
    idle();
    rd(8'h02, 1, 0, 32'hA5, "R8 locked read");
    wr(8'h03, 32'h33, 1, 0, "R3 neighbour write");
    rd(8'h03, 1, 0, 32'h33, "R3 neighbour read");
    wr(8'h82, 32'h0, 1, 0, "R4 release");
    wr(8'h02, 32'h77, 1, 0, "R4 write after release");
    rd(8'h02, 1, 0, 32'h77, "R4 read after release");
    wr(8'hC0, 32'h2, 1, 0, "R7 enable sup-only");
    rd(8'h02, 0, 1, 32'h0, "R7 user read");
    wr(8'h02, 32'h11, 0, 1, "R7 user write");
    rd(8'hC0, 0, 1, 32'h0, "R7 user window read");
    rd(8'h02, 1, 0, 32'h77, "R7 supervisor read");
    wr(8'hC0, 32'h3, 1, 0, "R5 set hard lock");
    rd(8'hC0, 1, 0, 32'h3, "R10 control readback");
    wr(8'h03, 32'h44, 1, 1, "R5 hard locked write");
    rd(8'h03, 1, 0, 32'h33, "R5 value kept");
    wr(8'h09, 32'h99, 1, 0, "R5 unprotected write");
    rd(8'h09, 1, 0, 32'h99, "R5 unprotected read");
    wr(8'h84, 32'h1, 1, 1, "R6 lock write frozen");
    rd(8'h84, 1, 0, 32'h0, "R6 lock unchanged");
    wr(8'hC0, 32'h0, 1, 1, "R6 control write frozen");
    rd(8'hC0, 1, 0, 32'h3, "R6 hard lock kept");
    idle();
    idle();
    do_reset();
    rd(8'hC0, 1, 0, 32'h0, "R10 control cleared");
    wr(8'h03, 32'h55, 1, 0, "R10 write after reset");
    rd(8'h03, 1, 0, 32'h55, "R10 read after reset");
    rd(8'h40, 1, 0, 32'h0, "R1 unprotected offset read");
    idle();
    idle();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    tests++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule